// File: doc/BRIEF.md
# Bridge Current Chopper with Thermal Fold-Back

This block regulates the current in a full bridge from digitised samples. Each clock it compares a low-side current code with a limit. When the code reaches the limit, it asks for both legs to be tri-stated for a fixed number of cycles. When that off interval ends, the bridge turns on again. A blanking window then starts in which the limit is ignored, so the chop repeats at a bounded rate for as long as the load keeps reaching the limit.

The blanking window also starts on every output activation, which the bridge controller signals with a one-cycle strobe. Two higher short-circuit thresholds, one for the high-side code and one for the low-side code, are checked in every cycle, including during blanking and off time. Crossing either one raises a one-cycle fault pulse, which the controller latches. The limit is derived from a junction temperature code. It is flat up to a knee temperature, falls linearly to a floor at the trip temperature, and stays at the floor above that. Any temperature above the trip point raises an over-temperature flag.

Top module: `chop_limiter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `tri_req`, `short_pulse` and `ot_trip` are 0. The limit starts at `LIM_NOM`.
- R2: When no off interval is running, no blanking window is open, and `ls_cur` is at or above the registered limit at a rising edge, `tri_req` is 1 after that edge. A code one below the limit never starts a chop.
- R3: `tri_req` stays high for exactly `OFF_CYC` cycles. A high `ls_cur` during that time neither extends nor restarts it.
- R4: An `act_stb` pulse opens a blanking window. For the next `BLANK_CYC` rising edges no chop starts, whatever `ls_cur` is.
- R5: The end of every off interval opens the same blanking window. A load that stays over the limit is therefore chopped with a period of `OFF_CYC + BLANK_CYC + 1` cycles.
- R6: The short condition is `hs_cur >= SC_HI` or `ls_cur >= SC_LO`. When it first becomes true it gives a `short_pulse` exactly one cycle wide, one cycle later. This happens whether or not blanking or an off interval is active. No further pulse follows until the condition has gone false.
- R7: The registered limit is `LIM_NOM` for `temp <= T_KNEE` and `LIM_FOLD` for `temp >= T_TRIP`. Between the two it is `LIM_NOM - floor((temp-T_KNEE)*(LIM_NOM-LIM_FOLD)/(T_TRIP-T_KNEE))`. It is updated at every edge from the `temp` seen at that edge.
- R8: `ot_trip` is 1 after an edge at which `temp > T_TRIP` and 0 after an edge at which `temp <= T_TRIP`.
- R9: An `act_stb` arriving inside an open blanking window restarts that window for a full `BLANK_CYC` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_stb | input | 1 | One-cycle strobe at each output activation |
| ls_cur | input | CUR_W | Low-side current code |
| hs_cur | input | CUR_W | High-side current code |
| temp | input | TEMP_W | Junction temperature code |
| tri_req | output | 1 | Tri-state request for current regulation |
| short_pulse | output | 1 | One-cycle short-circuit fault pulse |
| ot_trip | output | 1 | Over-temperature trip flag |

## Verification
A counter that is off by one shows up directly as an off interval or a blanking window one cycle too long or too short. This is visible at `tri_req` on the first chop after a strobe, and again at every repetition of the chop. A wrong slope, knee or floor in the temperature fold-back is seen only as a shifted threshold. So the limit is probed at codes one below and exactly at the expected limit for several temperatures, and the outcome appears at `tri_req` one cycle after the code is applied. A stuck short-edge register shows as a pulse wider than one cycle, or as a missing pulse, on the cycle after the short code is applied.

// File: rtl/chop_limiter.sv
module chop_limiter #(
  parameter int CUR_W     = 10,
  parameter int TEMP_W    = 8,
  parameter int OFF_CYC   = 1000,
  parameter int BLANK_CYC = 825,
  parameter int LIM_NOM   = 325,
  parameter int LIM_FOLD  = 200,
  parameter int SC_HI     = 550,
  parameter int SC_LO     = 400,
  parameter int T_KNEE    = 160,
  parameter int T_TRIP    = 175
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_stb,
  input  logic [CUR_W-1:0]  ls_cur,
  input  logic [CUR_W-1:0]  hs_cur,
  input  logic [TEMP_W-1:0] temp,
  output logic              tri_req,
  output logic              short_pulse,
  output logic              ot_trip
);
  localparam int OFF_W  = $clog2(OFF_CYC + 1);
  localparam int BLK_W  = $clog2(BLANK_CYC + 1);
  localparam int PW     = CUR_W + TEMP_W;
  localparam int DROP   = LIM_NOM - LIM_FOLD;
  localparam int T_SPAN = T_TRIP - T_KNEE;

  logic [OFF_W-1:0]  off_cnt;
  logic [BLK_W-1:0]  blank_cnt;
  logic [CUR_W-1:0]  lim_q, lim_next, drop_w;
  logic [TEMP_W-1:0] dt;
  logic              sc, sc_q, chop_go, off_last;

  assign dt     = temp - TEMP_W'(T_KNEE);
  assign drop_w = CUR_W'((PW'(dt) * PW'(DROP)) / PW'(T_SPAN));

  always_comb begin
    if (temp <= TEMP_W'(T_KNEE))      lim_next = CUR_W'(LIM_NOM);
    else if (temp >= TEMP_W'(T_TRIP)) lim_next = CUR_W'(LIM_FOLD);
    else                              lim_next = CUR_W'(LIM_NOM) - drop_w;
  end

  assign sc       = (hs_cur >= CUR_W'(SC_HI)) || (ls_cur >= CUR_W'(SC_LO));
  assign off_last = (off_cnt == OFF_W'(1));
  assign chop_go  = (off_cnt == '0) && (blank_cnt == '0) && (ls_cur >= lim_q);
  assign tri_req  = (off_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q       <= CUR_W'(LIM_NOM);
      ot_trip     <= 1'b0;
      sc_q        <= 1'b0;
      short_pulse <= 1'b0;
      off_cnt     <= '0;
      blank_cnt   <= '0;
    end else begin
      lim_q       <= lim_next;
      ot_trip     <= temp > TEMP_W'(T_TRIP);
      sc_q        <= sc;
      short_pulse <= sc & ~sc_q;
      if (off_cnt != '0)  off_cnt <= off_cnt - OFF_W'(1);
      else if (chop_go)   off_cnt <= OFF_W'(OFF_CYC);
      if (act_stb || off_last)   blank_cnt <= BLK_W'(BLANK_CYC);
      else if (blank_cnt != '0)  blank_cnt <= blank_cnt - BLK_W'(1);
    end
  end
endmodule

// File: rtl/chop_limiter_chk.sv
module chop_limiter_chk #(
  parameter int CUR_W     = 10,
  parameter int TEMP_W    = 8,
  parameter int OFF_CYC   = 1000,
  parameter int BLANK_CYC = 825,
  parameter int LIM_NOM   = 325,
  parameter int LIM_FOLD  = 200,
  parameter int SC_HI     = 550,
  parameter int SC_LO     = 400,
  parameter int T_TRIP    = 175
) (
  input logic              clk,
  input logic              rst_n,
  input logic              act_stb,
  input logic [CUR_W-1:0]  ls_cur,
  input logic [CUR_W-1:0]  hs_cur,
  input logic [TEMP_W-1:0] temp,
  input logic [CUR_W-1:0]  lim_q,
  input logic              tri_req,
  input logic              short_pulse,
  input logic              ot_trip
);
  localparam int LW = $clog2(OFF_CYC + 1) + 1;
  localparam int GW = $clog2(BLANK_CYC + 2) + 1;

  logic [LW-1:0] len;
  logic [GW-1:0] gap_act, gap_off;
  logic          tri_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len     <= '0;
      gap_act <= GW'(BLANK_CYC + 1);
      gap_off <= GW'(BLANK_CYC + 1);
      tri_d   <= 1'b0;
    end else begin
      tri_d <= tri_req;
      len   <= tri_req ? len + LW'(1) : '0;
      if (act_stb)                       gap_act <= '0;
      else if (gap_act <= GW'(BLANK_CYC)) gap_act <= gap_act + GW'(1);
      if (tri_d && !tri_req)             gap_off <= '0;
      else if (gap_off <= GW'(BLANK_CYC)) gap_off <= gap_off + GW'(1);
    end
  end

  a_r2_chop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tri_req) |-> $past(ls_cur) >= $past(lim_q));
  a_r3_off_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tri_req) |-> len == LW'(OFF_CYC));
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req |-> len < LW'(OFF_CYC));
  a_r4_blank_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tri_req) |-> gap_act > GW'(BLANK_CYC));
  a_r5_blank_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tri_req) |-> gap_off >= GW'(BLANK_CYC));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    short_pulse |=> !short_pulse);
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    short_pulse |-> $past(hs_cur >= CUR_W'(SC_HI) || ls_cur >= CUR_W'(SC_LO)));
  a_r7_limit_range: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q >= CUR_W'(LIM_FOLD) && lim_q <= CUR_W'(LIM_NOM));
  a_r8_trip_set: assert property (@(posedge clk) disable iff (!rst_n)
    temp > TEMP_W'(T_TRIP) |=> ot_trip);
  a_r8_trip_clear: assert property (@(posedge clk) disable iff (!rst_n)
    temp <= TEMP_W'(T_TRIP) |=> !ot_trip);
endmodule

bind chop_limiter chop_limiter_chk #(
  .CUR_W(CUR_W), .TEMP_W(TEMP_W), .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC),
  .LIM_NOM(LIM_NOM), .LIM_FOLD(LIM_FOLD), .SC_HI(SC_HI), .SC_LO(SC_LO),
  .T_TRIP(T_TRIP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .act_stb(act_stb), .ls_cur(ls_cur),
  .hs_cur(hs_cur), .temp(temp), .lim_q(lim_q), .tri_req(tri_req),
  .short_pulse(short_pulse), .ot_trip(ot_trip)
);

// File: tb/test_chop_limiter.sv
module test_chop_limiter;
  localparam int CW = 10, TW = 8, OFF = 20, BLK = 12;

  logic clk = 1'b0, rst_n = 1'b0, act_stb = 1'b0;
  logic [CW-1:0] ls_cur = '0, hs_cur = '0;
  logic [TW-1:0] temp = 8'd25;
  logic tri_req, short_pulse, ot_trip;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chop_limiter #(.CUR_W(CW), .TEMP_W(TW), .OFF_CYC(OFF), .BLANK_CYC(BLK)) i_chop_limiter (
    .clk(clk), .rst_n(rst_n), .act_stb(act_stb), .ls_cur(ls_cur), .hs_cur(hs_cur),
    .temp(temp), .tri_req(tri_req), .short_pulse(short_pulse), .ot_trip(ot_trip));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) act_stb = 1'b1;
    @(negedge clk) act_stb = 1'b0;
  endtask

  task automatic quiet_then_chop(input string req);
    int zeros = 0;
    for (int i = 0; i < BLK; i++) begin
      @(negedge clk);
      if (tri_req == 1'b0) zeros++;
    end
    chk(zeros == BLK, req, zeros, BLK);
    @(negedge clk);
    chk(tri_req == 1'b1, req, tri_req, 1);
  endtask

  task automatic settle();
    ls_cur = '0; hs_cur = '0;
    tick(OFF + BLK + 4);
  endtask

  task automatic t_reset();
    tick(3);
    chk({tri_req, short_pulse, ot_trip} == 3'b000, "R1 in reset", {tri_req, short_pulse, ot_trip}, 0);
    rst_n = 1'b1;
    tick(1);
    chk({tri_req, short_pulse, ot_trip} == 3'b000, "R1 after release", {tri_req, short_pulse, ot_trip}, 0);
    ls_cur = 10'd324; tick(1);
    ls_cur = 10'd0;   tick(1);
    chk(tri_req == 1'b0, "R1 R2 limit starts nominal, 324 below", tri_req, 0);
  endtask

  task automatic t_chop_cycle();
    int highs = 0;
    strobe();
    ls_cur = 10'd325;
    quiet_then_chop("R4 R2 chop after blanking");
    for (int i = 1; i < OFF; i++) begin
      @(negedge clk);
      if (tri_req) highs++;
    end
    chk(highs == OFF - 1, "R3 off interval length", highs + 1, OFF);
    @(negedge clk);
    chk(tri_req == 1'b0, "R3 off interval ends", tri_req, 0);
    quiet_then_chop("R5 blanking after off end then rechop");
    settle();
  endtask

  task automatic t_below();
    int any = 0;
    ls_cur = 10'd324;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tri_req) any++;
    end
    chk(any == 0, "R2 code below limit never chops", any, 0);
    settle();
  endtask

  task automatic probe(input int t, input int lim, input string req);
    temp = TW'(t); tick(2);
    ls_cur = CW'(lim - 1); tick(1);
    chk(tri_req == 1'b0, req, tri_req, 0);
    ls_cur = CW'(lim); tick(1);
    chk(tri_req == 1'b1, req, tri_req, 1);
    settle();
  endtask

  task automatic t_fold();
    probe(161, 317, "R7 fold at 161");
    probe(167, 267, "R7 fold at 167");
    probe(175, 200, "R7 floor at trip");
    probe(200, 200, "R7 floor above trip");
    probe(160, 325, "R7 nominal at knee");
    temp = 8'd25; tick(2);
  endtask

  task automatic t_trip();
    temp = 8'd175; tick(1);
    chk(ot_trip == 1'b0, "R8 no trip at 175", ot_trip, 0);
    temp = 8'd176; tick(1);
    chk(ot_trip == 1'b1, "R8 trip at 176", ot_trip, 1);
    temp = 8'd100; tick(1);
    chk(ot_trip == 1'b0, "R8 trip clears", ot_trip, 0);
    temp = 8'd25; tick(2);
  endtask

  task automatic t_short();
    strobe();
    ls_cur = 10'd400; tick(1);
    chk(short_pulse == 1'b1 && tri_req == 1'b0, "R6 low-side short inside blanking", {short_pulse, tri_req}, 2);
    tick(1);
    chk(short_pulse == 1'b0, "R6 pulse one cycle wide", short_pulse, 0);
    tick(3);
    chk(short_pulse == 1'b0, "R6 no repeat while held", short_pulse, 0);
    ls_cur = 10'd399; tick(2);
    chk(short_pulse == 1'b0, "R6 399 low side is no short", short_pulse, 0);
    settle();
    hs_cur = 10'd549; tick(2);
    chk(short_pulse == 1'b0, "R6 549 high side is no short", short_pulse, 0);
    hs_cur = 10'd550; tick(1);
    chk(short_pulse == 1'b1, "R6 high-side short", short_pulse, 1);
    hs_cur = 10'd0; tick(1);
    hs_cur = 10'd600; tick(1);
    chk(short_pulse == 1'b1, "R6 new pulse after clear", short_pulse, 1);
    settle();
    ls_cur = 10'd330; tick(3);
    hs_cur = 10'd560; tick(1);
    chk(short_pulse == 1'b1 && tri_req == 1'b1, "R6 short during off interval", {short_pulse, tri_req}, 3);
    settle();
  endtask

  task automatic t_restrike();
    strobe();
    ls_cur = 10'd330;
    tick(6);
    chk(tri_req == 1'b0, "R9 still blanked", tri_req, 0);
    @(negedge clk) act_stb = 1'b1;
    @(negedge clk) act_stb = 1'b0;
    quiet_then_chop("R9 window restarted by second strobe");
    settle();
  endtask

  initial begin
    t_reset();
    t_chop_cycle();
    t_below();
    t_fold();
    t_trip();
    t_short();
    t_restrike();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule